// File: doc/BRIEF.md
# Card Data Transfer Sequencer

This block sequences a single block-oriented data transfer for a memory-card host controller. When it is idle and receives a start request, it loads a byte counter from the programmed length and selects a direction. In the receive direction it waits for bytes from the card. In the send direction it passes bytes out, waits for the card to acknowledge, and then waits while the card reports busy. Every byte moves over a valid/ready handshake. Each handshake that completes reduces the remaining count by one. The transfer finishes successfully when the count reaches zero and, for a send, when the card has also released busy.

Two reloadable watchdog counters guard the transfer. The data timer runs only while the sequencer waits for received data or waits for the card to leave busy. The acknowledgment timer runs only while it waits for the card's acknowledgment. Both timers count card bus clock periods, which reach the block as a one-cycle enable, `bus_tick_i`. Every counter in the block advances only on such a tick. A timeout returns the sequencer to idle and raises its own one-cycle error pulse. The completion pulse is withheld for that transfer.

Byte stream rules: `byte_ready_o` is high only on tick cycles while the sequencer is in a data state. A byte moves in any cycle where `byte_valid_i` and `byte_ready_o` are both high. The producer or consumer may hold `byte_valid_i` low for as long as it needs to, and this is how back-pressure from the data side is applied. No byte moves outside a tick.

Top module: `card_dpath_seq`

## Requirements
- R1: After reset, `state_o` is idle (0), `remain_o` is 0, the three pulses are low and `byte_ready_o` is low.
- R2: In idle, `start_i` loads `remain_o` with `len_i` on the next edge. A nonzero length then enters send (`state_o`=1) when `dir_send_i`=1, or receive (`state_o`=2) when `dir_send_i`=0.
- R3: `byte_ready_o` is high exactly when `bus_tick_i` is high and the state is send or receive. Each cycle with `byte_valid_i` and `byte_ready_o` both high decrements `remain_o` by one.
- R4: In receive, the byte that brings `remain_o` to zero returns the sequencer to idle and raises `done_o` for one cycle.
- R5: In send, the last byte moves the sequencer to ack wait (`state_o`=4). A tick with `ack_i`=1 there enters busy wait (`state_o`=3). A tick with `busy_i`=0 in busy wait returns to idle with `done_o`.
- R6: The data timer loads `dto_i` on entry to receive or busy wait. The Nth tick in that state without progress, where N=`dto_i` and 0 counts as 1, returns to idle with `dto_o` high and `done_o` low. In receive, a final byte on that tick wins. In busy wait, busy release on that tick wins.
- R7: The ack timer loads `ato_i` on entry to ack wait. The Nth tick there without `ack_i`, where 0 counts as 1, returns to idle with `ato_o` high and `done_o` low.
- R8: The data timer does not run in send or ack wait, so any number of ticks in send produces no `dto_o`.
- R9: In a cycle with `bus_tick_i` low outside idle, the state and `remain_o` hold, even when `byte_valid_i`, `ack_i` or `busy_i` change.
- R10: A start with `len_i`=0 stays in idle, leaves `remain_o` at 0 and raises `done_o` on the next edge.
- R11: `start_i` is ignored outside idle: the state and `remain_o` are unchanged.
- R12: `done_o`, `dto_o` and `ato_o` are one-cycle pulses, and at most one of them is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_tick_i | input | 1 | One-cycle enable marking each card bus clock period |
| start_i | input | 1 | Start a transfer (only acted on in idle) |
| dir_send_i | input | 1 | 1 = send to card, 0 = receive from card |
| len_i | input | LEN_W | Transfer length in bytes |
| dto_i | input | TMO_W | Data timeout, in bus ticks |
| ato_i | input | TMO_W | Acknowledgment timeout, in bus ticks |
| byte_valid_i | input | 1 | Byte stream valid |
| byte_ready_o | output | 1 | Byte stream ready |
| ack_i | input | 1 | Card acknowledged the sent block |
| busy_i | input | 1 | Card is busy programming |
| state_o | output | 3 | 0 idle, 1 send, 2 receive, 3 busy wait, 4 ack wait |
| remain_o | output | LEN_W | Bytes left in the transfer |
| done_o | output | 1 | Successful completion pulse |
| dto_o | output | 1 | Data timeout pulse |
| ato_o | output | 1 | Ack timeout pulse |

## Verification
The hardest cases to reach are the timeouts that occur late in the send path. To get a data timeout in busy wait, the stimulus must first move every byte, then deliver an acknowledgment on a tick, and then hold busy for exactly the programmed number of ticks. The directed tasks drive each tick explicitly and keep `dto_i` small, so the firing tick is known. Every task also includes non-tick cycles with active inputs, which shows that nothing advances between bus clock periods.

// File: rtl/dps_pkg.sv
package dps_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_SEND = 3'd1,
    ST_RECV = 3'd2,
    ST_BUSY = 3'd3,
    ST_ACKW = 3'd4
  } dps_state_e;
endpackage

// File: rtl/dps_down_ctr.sv
module dps_down_ctr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         dec_i,
  output logic [W-1:0] count_o,
  output logic         last_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (load_i)                 cnt_q <= load_val_i;
    else if (dec_i && cnt_q != '0)   cnt_q <= cnt_q - W'(1);
  end

  assign count_o = cnt_q;
  // at most one step left (zero is treated as one)
  assign last_o  = (cnt_q <= W'(1));
endmodule

// File: rtl/dps_fsm.sv
module dps_fsm
  import dps_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       start_i,
  input  logic       dir_send_i,
  input  logic       len_zero_i,
  input  logic       xfer_i,
  input  logic       byte_last_i,
  input  logic       dt_last_i,
  input  logic       at_last_i,
  input  logic       ack_i,
  input  logic       busy_i,
  output dps_state_e state_o,
  output logic       ld_byte_o,
  output logic       ld_dt_o,
  output logic       ld_at_o,
  output logic       dec_dt_o,
  output logic       dec_at_o,
  output logic       done_o,
  output logic       dto_o,
  output logic       ato_o
);
  dps_state_e st_q, st_d;
  logic fin_ev, dto_ev, ato_ev;

  always_comb begin
    st_d      = st_q;
    ld_byte_o = 1'b0;
    ld_dt_o   = 1'b0;
    ld_at_o   = 1'b0;
    dec_dt_o  = 1'b0;
    dec_at_o  = 1'b0;
    fin_ev    = 1'b0;
    dto_ev    = 1'b0;
    ato_ev    = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start_i) begin
        ld_byte_o = 1'b1;
        if (len_zero_i)      fin_ev = 1'b1;
        else if (dir_send_i) st_d = ST_SEND;
        else begin
          st_d    = ST_RECV;
          ld_dt_o = 1'b1;
        end
      end
      ST_RECV: begin
        if (xfer_i && byte_last_i) begin
          st_d   = ST_IDLE;
          fin_ev = 1'b1;
        end else if (tick_i) begin
          if (dt_last_i) begin
            st_d   = ST_IDLE;
            dto_ev = 1'b1;
          end else dec_dt_o = 1'b1;
        end
      end
      ST_SEND: if (xfer_i && byte_last_i) begin
        st_d    = ST_ACKW;
        ld_at_o = 1'b1;
      end
      ST_ACKW: if (tick_i) begin
        if (ack_i) begin
          st_d    = ST_BUSY;
          ld_dt_o = 1'b1;
        end else if (at_last_i) begin
          st_d   = ST_IDLE;
          ato_ev = 1'b1;
        end else dec_at_o = 1'b1;
      end
      ST_BUSY: if (tick_i) begin
        if (!busy_i) begin
          st_d   = ST_IDLE;
          fin_ev = 1'b1;
        end else if (dt_last_i) begin
          st_d   = ST_IDLE;
          dto_ev = 1'b1;
        end else dec_dt_o = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      done_o <= 1'b0;
      dto_o  <= 1'b0;
      ato_o  <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_o <= fin_ev;
      dto_o  <= dto_ev;
      ato_o  <= ato_ev;
    end
  end

  assign state_o = st_q;
endmodule

// File: rtl/card_dpath_seq.sv
module card_dpath_seq
  import dps_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_tick_i,
  input  logic             start_i,
  input  logic             dir_send_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [TMO_W-1:0] dto_i,
  input  logic [TMO_W-1:0] ato_i,
  input  logic             byte_valid_i,
  output logic             byte_ready_o,
  input  logic             ack_i,
  input  logic             busy_i,
  output logic [2:0]       state_o,
  output logic [LEN_W-1:0] remain_o,
  output logic             done_o,
  output logic             dto_o,
  output logic             ato_o
);
  dps_state_e st;
  logic xfer, byte_last, dt_last, at_last;
  logic ld_byte, ld_dt, ld_at, dec_dt, dec_at;
  logic [TMO_W-1:0] dt_cnt, at_cnt;

  assign byte_ready_o = bus_tick_i && (st == ST_RECV || st == ST_SEND);
  assign xfer         = byte_valid_i && byte_ready_o;

  dps_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (bus_tick_i),
    .start_i    (start_i),
    .dir_send_i (dir_send_i),
    .len_zero_i (len_i == '0),
    .xfer_i     (xfer),
    .byte_last_i(byte_last),
    .dt_last_i  (dt_last),
    .at_last_i  (at_last),
    .ack_i      (ack_i),
    .busy_i     (busy_i),
    .state_o    (st),
    .ld_byte_o  (ld_byte),
    .ld_dt_o    (ld_dt),
    .ld_at_o    (ld_at),
    .dec_dt_o   (dec_dt),
    .dec_at_o   (dec_at),
    .done_o     (done_o),
    .dto_o      (dto_o),
    .ato_o      (ato_o)
  );

  dps_down_ctr #(.W(LEN_W)) u_byte_ctr (
    .clk(clk), .rst_n(rst_n), .load_i(ld_byte), .load_val_i(len_i),
    .dec_i(xfer), .count_o(remain_o), .last_o(byte_last)
  );

  dps_down_ctr #(.W(TMO_W)) u_data_tmr (
    .clk(clk), .rst_n(rst_n), .load_i(ld_dt), .load_val_i(dto_i),
    .dec_i(dec_dt), .count_o(dt_cnt), .last_o(dt_last)
  );

  dps_down_ctr #(.W(TMO_W)) u_ack_tmr (
    .clk(clk), .rst_n(rst_n), .load_i(ld_at), .load_val_i(ato_i),
    .dec_i(dec_at), .count_o(at_cnt), .last_o(at_last)
  );

  assign state_o = st;
endmodule

// File: rtl/dps_checker.sv
module dps_checker
  import dps_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int TMO_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_tick_i,
  input logic             start_i,
  input logic             dir_send_i,
  input logic [LEN_W-1:0] len_i,
  input logic [TMO_W-1:0] dto_i,
  input logic [TMO_W-1:0] ato_i,
  input logic             byte_valid_i,
  input logic             byte_ready_o,
  input logic             ack_i,
  input logic             busy_i,
  input logic [2:0]       state_o,
  input logic [LEN_W-1:0] remain_o,
  input logic             done_o,
  input logic             dto_o,
  input logic             ato_o
);
  AST_START_LOADS_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_IDLE && start_i) |=> remain_o == $past(len_i)); // R2

  AST_READY_WHEN_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    byte_ready_o |-> (bus_tick_i && (state_o == ST_RECV || state_o == ST_SEND))); // R3

  AST_BYTE_DECREMENTS: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid_i && byte_ready_o) |=> remain_o == $past(remain_o) - LEN_W'(1)); // R3

  AST_DONE_IN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> state_o == ST_IDLE); // R4

  AST_DTO_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dto_o) |-> ($past(state_o) == ST_RECV || $past(state_o) == ST_BUSY)); // R6

  AST_ATO_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ato_o) |-> $past(state_o) == ST_ACKW); // R7

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_tick_i && state_o != ST_IDLE) |=> (state_o == $past(state_o) && remain_o == $past(remain_o))); // R9

  AST_PULSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_o, dto_o, ato_o})); // R12
endmodule

bind card_dpath_seq dps_checker #(.LEN_W(LEN_W), .TMO_W(TMO_W)) u_chk (.*);

// File: tb/card_dpath_seq_test.sv
module card_dpath_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int LW = 16;
  localparam int TW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, start = 1'b0, dsend = 1'b0, valid = 1'b0, ack = 1'b0, busy = 1'b0;
  logic [LW-1:0] len = '0;
  logic [TW-1:0] dto = '0, ato = '0;
  logic ready, done, dtmo, atmo;
  logic [2:0] state;
  logic [LW-1:0] remain;
  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  card_dpath_seq #(.LEN_W(LW), .TMO_W(TW)) uut (
    .clk(clk), .rst_n(rst_n), .bus_tick_i(tick), .start_i(start), .dir_send_i(dsend),
    .len_i(len), .dto_i(dto), .ato_i(ato), .byte_valid_i(valid), .byte_ready_o(ready),
    .ack_i(ack), .busy_i(busy), .state_o(state), .remain_o(remain),
    .done_o(done), .dto_o(dtmo), .ato_o(atmo)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // apply inputs at negedge, advance one edge, settle
  task automatic step(input logic t, input logic s, input logic v, input logic a, input logic b);
    @(negedge clk);
    tick = t; start = s; valid = v; ack = a; busy = b;
    @(posedge clk);
    #1;
  endtask

  task automatic chk_st(input string req, input int exp);
    chk(state == exp, req, state, exp);
  endtask

  task automatic t_reset();
    chk_st("R1 state", 0);
    chk(remain == 0, "R1 remain", remain, 0);
    chk({done, dtmo, atmo} == 3'b000, "R1 pulses", {done, dtmo, atmo}, 0);
    chk(ready == 1'b0, "R1 ready", ready, 0);
  endtask

  task automatic t_recv();
    len = 3; dto = 20; dsend = 0;
    step(0, 1, 0, 0, 0);
    chk_st("R2 recv state", 2);
    chk(remain == 3, "R2 remain load", remain, 3);
    chk(ready == 1'b0, "R3 ready low without tick", ready, 0);
    step(1, 0, 1, 0, 0);
    chk(remain == 2, "R3 decrement", remain, 2);
    chk(ready == 1'b1, "R3 ready on tick", ready, 1);
    step(0, 0, 1, 1, 1);
    chk(remain == 2, "R9 hold remain", remain, 2);
    chk_st("R9 hold state", 2);
    len = 9;
    step(0, 1, 0, 0, 0);
    chk(remain == 2, "R11 start ignored remain", remain, 2);
    chk_st("R11 start ignored state", 2);
    step(1, 0, 0, 0, 0);
    chk(remain == 2, "R3 no valid no decrement", remain, 2);
    step(1, 0, 1, 0, 0);
    chk(remain == 1, "R3 decrement 2", remain, 1);
    step(1, 0, 1, 0, 0);
    chk_st("R4 back to idle", 0);
    chk(done == 1'b1, "R4 done pulse", done, 1);
    chk(remain == 0, "R4 remain zero", remain, 0);
    step(0, 0, 0, 0, 0);
    chk(done == 1'b0, "R12 done one cycle", done, 0);
  endtask

  task automatic t_send();
    len = 2; dto = 3; ato = 5; dsend = 1;
    step(0, 1, 0, 0, 0);
    chk_st("R2 send state", 1);
    for (int i = 0; i < 6; i++) step(1, 0, 0, 0, 0);
    chk_st("R8 still sending", 1);
    chk(dtmo == 1'b0, "R8 no data timeout in send", dtmo, 0);
    step(1, 0, 1, 0, 0);
    step(1, 0, 1, 0, 0);
    chk_st("R5 ack wait", 4);
    step(0, 0, 0, 1, 0);
    chk_st("R9 ack ignored off tick", 4);
    step(1, 0, 0, 1, 1);
    chk_st("R5 busy wait", 3);
    step(1, 0, 0, 0, 1);
    step(1, 0, 0, 0, 1);
    chk_st("R5 still busy", 3);
    step(1, 0, 0, 0, 0);
    chk_st("R5 idle after busy", 0);
    chk(done == 1'b1, "R5 done", done, 1);
  endtask

  task automatic t_dto_recv();
    len = 4; dto = 3; dsend = 0;
    step(0, 1, 0, 0, 0);
    step(1, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0);
    chk_st("R6 before timeout", 2);
    chk(dtmo == 1'b0, "R6 no early timeout", dtmo, 0);
    step(1, 0, 0, 0, 0);
    chk_st("R6 idle on timeout", 0);
    chk(dtmo == 1'b1, "R6 dto pulse", dtmo, 1);
    chk(done == 1'b0, "R6 no done", done, 0);
    step(0, 0, 0, 0, 0);
    chk(dtmo == 1'b0, "R12 dto one cycle", dtmo, 0);
  endtask

  task automatic t_dto_busy();
    len = 1; dto = 2; ato = 5; dsend = 1;
    step(0, 1, 0, 0, 0);
    step(1, 0, 1, 0, 0);
    step(1, 0, 0, 1, 1);
    chk_st("R6 busy entered", 3);
    step(1, 0, 0, 0, 1);
    chk_st("R6 busy first tick", 3);
    step(1, 0, 0, 0, 1);
    chk(dtmo == 1'b1, "R6 busy timeout", dtmo, 1);
    chk(done == 1'b0, "R6 busy no done", done, 0);
    chk_st("R6 busy to idle", 0);
  endtask

  task automatic t_ato();
    len = 1; ato = 3; dsend = 1;
    step(0, 1, 0, 0, 0);
    step(1, 0, 1, 0, 0);
    step(1, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0);
    chk_st("R7 before ack timeout", 4);
    step(1, 0, 0, 0, 0);
    chk(atmo == 1'b1, "R7 ack timeout", atmo, 1);
    chk(done == 1'b0, "R7 no done", done, 0);
    chk(dtmo == 1'b0, "R12 exclusive", dtmo, 0);
    chk_st("R7 idle", 0);
  endtask

  task automatic t_zero();
    len = 0; dsend = 0;
    step(0, 1, 0, 0, 0);
    chk_st("R10 stays idle", 0);
    chk(done == 1'b1, "R10 done", done, 1);
    chk(remain == 0, "R10 remain", remain, 0);
    step(1, 0, 0, 0, 0);
    chk(done == 1'b0, "R10 done one cycle", done, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_recv();
    t_send();
    t_dto_recv();
    t_dto_busy();
    t_ato();
    t_zero();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule